// File: doc/BRIEF.md
# Scatter-Gather Descriptor Segmenter

This block turns a list of scatter-gather segments into the physical region descriptor table that a bus-master disk DMA engine walks. A segment is a 32-bit bus address and a byte length. Each descriptor the block emits is two 32-bit words: an address word, then a count word. The block cuts every segment so that no descriptor spans a 64 KB address window. It counts the descriptors against a table capacity parameter. When the table would overflow, or when the list holds no bytes at all, it reports that the transfer must fall back to programmed I/O.

Segments arrive on a valid/ready input and carry a last flag that closes the list. Descriptor words leave on a valid/ready output, together with a flag that marks count words. The newest descriptor is held back until a later one arrives or the list closes. This lets the end-of-table mark be written into the final count word before that word leaves.

Two mode inputs change the encoding:
- The split mode serves controllers that read a zero count field as zero bytes instead of 64 KB.
- The alternate encoding mode places a word-based count in the upper half of the count word.

Both mode inputs must be held steady for the whole of a list. When the list has been handled, a one-cycle done pulse reports the descriptor count, or zero together with the fallback flag.

Top module: `prd_segmenter`

## Requirements
- R1: After reset, `prd_valid` and `done` are low and `seg_ready` is high.
- R2: Each piece cut from a segment has length min(0x10000 − address[15:0], remaining bytes). The address and the remaining length advance by that amount, so no descriptor crosses a 64 KB boundary.
- R3: In the normal encoding, a count word holds the piece length in bits 15:0, where 0x0000 stands for 64 KB, and bits 30:16 are zero.
- R4: Descriptor words leave as an address word (`prd_is_count`=0) followed by its count word (`prd_is_count`=1), in segment order.
- R5: In the normal encoding, bit 31 of the final count word of a list is set, and it is clear in every other count word.
- R6: With `cfg_split_full`=1 in the normal encoding, a full 64 KB piece becomes two descriptors of count 0x8000, at the piece address and at the piece address + 0x8000. With `cfg_split_full`=0, the same piece becomes one descriptor with count field 0x0000.
- R7: With `cfg_alt_enc`=1, the count word is ((len16 >> 2) − 1) << 16, computed modulo 2^32, where len16 is the piece length modulo 0x10000. No end mark is added and no piece is split.
- R8: If a descriptor, or both halves of a split, would take the count past TABLE_DEPTH, the list aborts. The remaining segments up to the last one are accepted and discarded, and `done` reports fallback with count 0. A list that fills the table exactly completes normally.
- R9: A list whose segments all have zero length emits no words and reports fallback with count 0.
- R10: After the last word of a list has been accepted, `done` pulses for one cycle with `done_count` equal to the number of descriptors emitted.
- R11: While `prd_valid` is high and `prd_ready` is low, `prd_word` and `prd_is_count` hold their values.
- R12: A zero-length segment inside a list contributes no descriptor and leaves the segments around it unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_split_full | input | 1 | Split each full 64 KB piece into two 32 KB descriptors |
| cfg_alt_enc | input | 1 | Alternate count encoding, no end mark |
| seg_valid | input | 1 | Segment offered |
| seg_ready | output | 1 | Segment accepted when high with seg_valid |
| seg_addr | input | 32 | Segment bus address |
| seg_len | input | LEN_W | Segment length in bytes |
| seg_last | input | 1 | Segment closes the list |
| prd_valid | output | 1 | Descriptor word offered |
| prd_ready | input | 1 | Descriptor word accepted |
| prd_word | output | 32 | Address or count word |
| prd_is_count | output | 1 | 1 for a count word, 0 for an address word |
| done | output | 1 | One-cycle list completion pulse |
| done_count | output | $clog2(TABLE_DEPTH+1) | Descriptors emitted, 0 on fallback |
| done_fallback | output | 1 | List must be handled without DMA |

## Verification
Segments are placed to separate the cutting cases:
- A small segment inside a single window.
- A segment straddling a window edge, which shows the 64 KB cut.
- A window-aligned 64 KB segment, run with the split mode off and on, which shows the zero-count encoding against the two-half form.
- A short segment in the alternate encoding, which shows the shifted count and the missing end mark.

Lists with a zero-length middle segment, and lists with only zero-length segments, separate skipping from fallback. Capacity is probed twice: with a split list that fills the table exactly, and with one piece-heavy segment that overflows it, followed by a list that shows recovery. Output backpressure is random in some cases, so the held-back count word must keep its end mark while the consumer stalls.

// File: rtl/prd_pkg.sv
package prd_pkg;
  localparam int WORD_W = 32;
  localparam int WIN_BITS = 16;
  localparam logic [WORD_W-1:0] END_MARK = 32'h8000_0000;
  localparam logic [WORD_W-1:0] HALF_WIN = 32'h0000_8000;

  typedef struct packed {
    logic [WORD_W-1:0] addr;
    logic [WORD_W-1:0] cnt;
  } prd_desc_t;

  typedef enum logic [2:0] {
    ST_TAKE,
    ST_CUT,
    ST_DRAIN,
    ST_CLOSE,
    ST_WAIT
  } seq_state_t;
endpackage

// File: rtl/prd_piece_gen.sv
// Walks one segment and presents the next window-bounded piece.
module prd_piece_gen #(
  parameter int LEN_W = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      load,
  input  logic [31:0]               load_addr,
  input  logic [LEN_W-1:0]          load_len,
  input  logic                      take,
  output logic                      busy,
  output logic [31:0]               piece_addr,
  output logic [prd_pkg::WIN_BITS:0] piece_len
);
  import prd_pkg::*;

  localparam logic [WIN_BITS:0] WIN_SIZE = {1'b1, {WIN_BITS{1'b0}}};

  logic [31:0]       cur_addr;
  logic [LEN_W-1:0]  rem;
  logic [WIN_BITS:0] room;

  assign room       = WIN_SIZE - {1'b0, cur_addr[WIN_BITS-1:0]};
  assign busy       = (rem != '0);
  assign piece_addr = cur_addr;

  always_comb begin
    if (64'(rem) < 64'(room)) piece_len = rem[WIN_BITS:0];
    else                      piece_len = room;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_addr <= '0;
      rem      <= '0;
    end else if (load) begin
      cur_addr <= load_addr;
      rem      <= load_len;
    end else if (take) begin
      cur_addr <= cur_addr + 32'(piece_len);
      rem      <= rem - LEN_W'(piece_len);
    end
  end
endmodule

// File: rtl/prd_count_enc.sv
// Forms the count word of a piece and decides whether it must be halved.
module prd_count_enc (
  input  logic [prd_pkg::WIN_BITS-1:0] len16,
  input  logic                         alt_enc,
  input  logic                         split_full,
  output logic                         halve,
  output logic [prd_pkg::WORD_W-1:0]   cnt_word
);
  import prd_pkg::*;

  logic [WORD_W-1:0] len_ext;
  assign len_ext = {{(WORD_W-WIN_BITS){1'b0}}, len16};

  always_comb begin
    if (alt_enc) begin
      halve    = 1'b0;
      cnt_word = ((len_ext >> 2) - 32'd1) << 16;
    end else if (split_full && (len16 == '0)) begin
      halve    = 1'b1;
      cnt_word = HALF_WIN;
    end else begin
      halve    = 1'b0;
      cnt_word = len_ext;
    end
  end
endmodule

// File: rtl/prd_hold_stage.sv
// Keeps the newest descriptor back and serialises older ones as two words.
module prd_hold_stage (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  prd_pkg::prd_desc_t         in_desc,
  input  logic                       flush,
  input  logic                       flush_mark,
  input  logic                       drop,
  output logic                       idle,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [prd_pkg::WORD_W-1:0] out_word,
  output logic                       out_is_cnt
);
  import prd_pkg::*;

  prd_desc_t         pend_q;
  logic              pend_v;
  logic [WORD_W-1:0] tail_q;

  assign in_ready = !out_valid;
  assign idle     = !out_valid && !pend_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q     <= '0;
      pend_v     <= 1'b0;
      tail_q     <= '0;
      out_valid  <= 1'b0;
      out_word   <= '0;
      out_is_cnt <= 1'b0;
    end else begin
      if (out_valid && out_ready) begin
        if (!out_is_cnt) begin
          out_word   <= tail_q;
          out_is_cnt <= 1'b1;
        end else begin
          out_valid  <= 1'b0;
          out_is_cnt <= 1'b0;
        end
      end
      if (drop) begin
        pend_v <= 1'b0;
      end else if (!out_valid) begin
        if (in_valid) begin
          pend_q <= in_desc;
          pend_v <= 1'b1;
          if (pend_v) begin
            out_valid  <= 1'b1;
            out_word   <= pend_q.addr;
            out_is_cnt <= 1'b0;
            tail_q     <= pend_q.cnt;
          end
        end else if (flush && pend_v) begin
          pend_v     <= 1'b0;
          out_valid  <= 1'b1;
          out_word   <= pend_q.addr;
          out_is_cnt <= 1'b0;
          tail_q     <= flush_mark ? (pend_q.cnt | END_MARK) : pend_q.cnt;
        end
      end
    end
  end
endmodule

// File: rtl/prd_segmenter.sv
module prd_segmenter #(
  parameter int TABLE_DEPTH = 32,
  parameter int LEN_W       = 32,
  localparam int CNT_W      = $clog2(TABLE_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_split_full,
  input  logic             cfg_alt_enc,
  input  logic             seg_valid,
  output logic             seg_ready,
  input  logic [31:0]      seg_addr,
  input  logic [LEN_W-1:0] seg_len,
  input  logic             seg_last,
  output logic             prd_valid,
  input  logic             prd_ready,
  output logic [31:0]      prd_word,
  output logic             prd_is_count,
  output logic             done,
  output logic [CNT_W-1:0] done_count,
  output logic             done_fallback
);
  import prd_pkg::*;

  seq_state_t        st;
  logic [CNT_W-1:0]  n_desc;
  logic              fb_q, last_q, half_q;

  logic              gen_busy, gen_load, gen_take;
  logic [31:0]       piece_addr;
  logic [WIN_BITS:0] piece_len;
  logic              enc_halve;
  logic [31:0]       enc_cnt;
  logic              h_in_valid, h_in_ready, h_flush, h_drop, h_idle;
  prd_desc_t         h_desc;
  logic              fits, fits_ok;

  prd_piece_gen #(.LEN_W(LEN_W)) i_piece (
    .clk(clk), .rst(rst), .load(gen_load), .load_addr(seg_addr),
    .load_len(seg_len), .take(gen_take), .busy(gen_busy),
    .piece_addr(piece_addr), .piece_len(piece_len)
  );

  prd_count_enc i_enc (
    .len16(piece_len[WIN_BITS-1:0]), .alt_enc(cfg_alt_enc),
    .split_full(cfg_split_full), .halve(enc_halve), .cnt_word(enc_cnt)
  );

  prd_hold_stage i_hold (
    .clk(clk), .rst(rst), .in_valid(h_in_valid), .in_ready(h_in_ready),
    .in_desc(h_desc), .flush(h_flush), .flush_mark(!cfg_alt_enc),
    .drop(h_drop), .idle(h_idle), .out_valid(prd_valid),
    .out_ready(prd_ready), .out_word(prd_word), .out_is_cnt(prd_is_count)
  );

  assign fits    = (32'(n_desc) + (enc_halve ? 32'd2 : 32'd1)) <= 32'(TABLE_DEPTH);
  assign fits_ok = half_q || fits;

  assign seg_ready  = (st == ST_TAKE) || (st == ST_DRAIN);
  assign gen_load   = (st == ST_TAKE) && seg_valid;
  assign h_in_valid = (st == ST_CUT) && gen_busy && fits_ok && h_in_ready;
  assign gen_take   = h_in_valid && (!enc_halve || half_q);
  assign h_drop     = (st == ST_CUT) && gen_busy && !fits_ok;
  assign h_flush    = (st == ST_CLOSE) && (n_desc != '0) && h_in_ready;

  always_comb begin
    if (half_q) begin
      h_desc.addr = piece_addr + HALF_WIN;
      h_desc.cnt  = HALF_WIN;
    end else begin
      h_desc.addr = piece_addr;
      h_desc.cnt  = enc_cnt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= ST_TAKE;
      n_desc        <= '0;
      fb_q          <= 1'b0;
      last_q        <= 1'b0;
      half_q        <= 1'b0;
      done          <= 1'b0;
      done_count    <= '0;
      done_fallback <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_TAKE: begin
          if (seg_valid) begin
            last_q <= seg_last;
            st     <= ST_CUT;
          end
        end
        ST_CUT: begin
          if (!gen_busy) begin
            st <= last_q ? ST_CLOSE : ST_TAKE;
          end else if (!fits_ok) begin
            fb_q   <= 1'b1;
            half_q <= 1'b0;
            st     <= last_q ? ST_WAIT : ST_DRAIN;
          end else if (h_in_ready) begin
            n_desc <= n_desc + 1'b1;
            half_q <= enc_halve && !half_q;
          end
        end
        ST_DRAIN: begin
          if (seg_valid && seg_last) st <= ST_WAIT;
        end
        ST_CLOSE: begin
          if (n_desc == '0) begin
            fb_q <= 1'b1;
            st   <= ST_WAIT;
          end else if (h_in_ready) begin
            st <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (h_idle) begin
            done          <= 1'b1;
            done_count    <= fb_q ? '0 : n_desc;
            done_fallback <= fb_q;
            n_desc        <= '0;
            fb_q          <= 1'b0;
            st            <= ST_TAKE;
          end
        end
        default: st <= ST_TAKE;
      endcase
    end
  end
endmodule

// File: rtl/prd_segmenter_chk.sv
module prd_segmenter_chk #(
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_alt_enc,
  input logic             prd_valid,
  input logic             prd_ready,
  input logic [31:0]      prd_word,
  input logic             prd_is_count,
  input logic             done,
  input logic [CNT_W-1:0] done_count,
  input logic             done_fallback
);
  logic        expect_cnt_q;
  logic [15:0] last_lo_q;
  logic [17:0] span;

  assign span = (prd_word[15:0] == 16'h0) ? 18'h10000 : {2'b00, prd_word[15:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      expect_cnt_q <= 1'b0;
      last_lo_q    <= '0;
    end else if (prd_valid && prd_ready) begin
      expect_cnt_q <= !prd_is_count;
      if (!prd_is_count) last_lo_q <= prd_word[15:0];
    end
  end

  AST_WORD_ORDER: assert property (@(posedge clk) disable iff (rst)
    prd_valid |-> (prd_is_count == expect_cnt_q)); // R4
  AST_NO_CROSS: assert property (@(posedge clk) disable iff (rst)
    (prd_valid && prd_is_count && !cfg_alt_enc) |-> ({2'b00, last_lo_q} + span) <= 18'h10000); // R2
  AST_CNT_FIELDS: assert property (@(posedge clk) disable iff (rst)
    (prd_valid && prd_is_count && !cfg_alt_enc) |-> (prd_word[30:16] == 15'h0)); // R3
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (prd_valid && !prd_ready) |=> (prd_valid && $stable(prd_word) && $stable(prd_is_count))); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10
  AST_FALLBACK_ZERO: assert property (@(posedge clk) disable iff (rst)
    (done && done_fallback) |-> (done_count == '0)); // R8
endmodule

bind prd_segmenter prd_segmenter_chk #(.CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst(rst), .cfg_alt_enc(cfg_alt_enc), .prd_valid(prd_valid),
  .prd_ready(prd_ready), .prd_word(prd_word), .prd_is_count(prd_is_count),
  .done(done), .done_count(done_count), .done_fallback(done_fallback)
);

// File: tb/test_prd_segmenter.sv
module test_prd_segmenter;
  localparam int DEPTH = 8;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_split_full = 1'b0, cfg_alt_enc = 1'b0;
  logic seg_valid = 1'b0, seg_last = 1'b0, seg_ready;
  logic [31:0] seg_addr = '0, seg_len = '0;
  logic prd_valid, prd_ready = 1'b1, prd_is_count;
  logic [31:0] prd_word;
  logic done, done_fallback;
  logic [CW-1:0] done_count;

  int n_chk = 0, n_bad = 0, cycles = 0;
  logic rnd_ready = 1'b0;
  logic [7:0] lfsr = 8'h5A;

  logic [31:0] sa [0:7];
  logic [31:0] sl [0:7];
  int ns;
  logic [31:0] exp_w [0:63];
  logic        exp_k [0:63];
  int exp_n, exp_cnt; logic exp_fb;
  logic [31:0] got_w [0:63];
  logic        got_k [0:63];
  int got_n; logic done_seen; int done_cnt_s; logic done_fb_s;
  logic prev_stall = 1'b0, hold_viol = 1'b0; logic [31:0] prev_w = '0;

  prd_segmenter #(.TABLE_DEPTH(DEPTH), .LEN_W(32)) i_prd_segmenter (
    .clk(clk), .rst(rst), .cfg_split_full(cfg_split_full), .cfg_alt_enc(cfg_alt_enc),
    .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr),
    .seg_len(seg_len), .seg_last(seg_last), .prd_valid(prd_valid),
    .prd_ready(prd_ready), .prd_word(prd_word), .prd_is_count(prd_is_count),
    .done(done), .done_count(done_count), .done_fallback(done_fallback)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    prd_ready <= rnd_ready ? (lfsr[0] | lfsr[2]) : 1'b1;
  end

  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      if (prev_stall && (!prd_valid || prd_word != prev_w)) hold_viol = 1'b1;
      prev_stall = prd_valid && !prd_ready;
      prev_w = prd_word;
      if (prd_valid && prd_ready && got_n < 64) begin
        got_w[got_n] = prd_word; got_k[got_n] = prd_is_count; got_n++;
      end
      if (done) begin
        done_seen = 1'b1; done_cnt_s = int'(done_count); done_fb_s = done_fallback;
      end
    end
    if (cycles > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not end, got %0d expected finish", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, expv);
    end
  endtask

  task automatic put(input logic [31:0] a, input logic [31:0] c);
    exp_w[exp_n] = a; exp_k[exp_n] = 1'b0;
    exp_w[exp_n+1] = c; exp_k[exp_n+1] = 1'b1;
    exp_n += 2;
  endtask

  // Reference built from the requirement text.
  task automatic model(input logic split, input logic alt);
    logic [31:0] a, l, b, c, l16; logic [32:0] room; logic two;
    exp_n = 0; exp_cnt = 0; exp_fb = 1'b0;
    for (int i = 0; i < ns; i++) begin
      a = sa[i]; l = sl[i];
      while (l != 0 && !exp_fb) begin
        room = 33'h10000 - {17'h0, a[15:0]};
        b = ({1'b0, l} < room) ? l : room[31:0];
        l16 = b & 32'hFFFF;
        if (alt) begin c = ((l16 >> 2) - 32'd1) << 16; two = 1'b0; end
        else begin c = l16; two = split && (l16 == 0); end
        if (exp_cnt + (two ? 2 : 1) > DEPTH) exp_fb = 1'b1;
        else begin
          if (two) begin put(a, 32'h8000); put(a + 32'h8000, 32'h8000); exp_cnt += 2; end
          else begin put(a, c); exp_cnt += 1; end
          a = a + b; l = l - b;
        end
      end
    end
    if (!exp_fb && exp_cnt == 0) exp_fb = 1'b1;
    if (!exp_fb && !alt) exp_w[exp_n-1] = exp_w[exp_n-1] | 32'h8000_0000;
    if (exp_fb) begin
      exp_n = (exp_cnt > 0) ? 2 * (exp_cnt - 1) : 0;
      exp_cnt = 0;
    end
  endtask

  task automatic send_list();
    for (int i = 0; i < ns; i++) begin
      seg_valid = 1'b1; seg_addr = sa[i]; seg_len = sl[i]; seg_last = (i == ns - 1);
      while (!seg_ready) @(negedge clk);
      @(negedge clk);
    end
    seg_valid = 1'b0; seg_last = 1'b0;
  endtask

  task automatic run_case(input string tag, input logic split, input logic alt, input logic rr);
    int w;
    cfg_split_full = split; cfg_alt_enc = alt; rnd_ready = rr;
    @(negedge clk);
    got_n = 0; done_seen = 1'b0; hold_viol = 1'b0;
    model(split, alt);
    send_list();
    w = 0;
    while (!done_seen && w < 3000) begin @(negedge clk); w++; end
    check({tag, " done pulse"}, 32'(done_seen), 32'd1);
    check({tag, " R10 count"}, 32'(done_cnt_s), 32'(exp_cnt));
    check({tag, " fallback"}, 32'(done_fb_s), 32'(exp_fb));
    check({tag, " word total"}, 32'(got_n), 32'(exp_n));
    for (int k = 0; k < exp_n && k < got_n; k++) begin
      check({tag, " word"}, got_w[k], exp_w[k]);
      check({tag, " R4 kind"}, 32'(got_k[k]), 32'(exp_k[k]));
    end
    check({tag, " R11 hold"}, 32'(hold_viol), 32'd0);
  endtask

  task automatic t_reset();
    check("R1 prd_valid", 32'(prd_valid), 32'd0);
    check("R1 seg_ready", 32'(seg_ready), 32'd1);
    check("R1 done", 32'(done), 32'd0);
  endtask
  task automatic t_small();
    ns = 1; sa[0] = 32'h1000_0100; sl[0] = 32'h200;
    run_case("R3/R5 small", 1'b0, 1'b0, 1'b0);
    check("R5 end mark", exp_w[1], 32'h8000_0200);
  endtask
  task automatic t_cross();
    ns = 1; sa[0] = 32'h0001_FF00; sl[0] = 32'h300;
    run_case("R2 cross", 1'b0, 1'b0, 1'b1);
  endtask
  task automatic t_multi();
    ns = 3; sa[0] = 32'h0004_FFF0; sl[0] = 32'h20;
    sa[1] = 32'h0900_0000; sl[1] = 32'h0;
    sa[2] = 32'h0007_8000; sl[2] = 32'h18000;
    run_case("R12 zero mid", 1'b0, 1'b0, 1'b1);
  endtask
  task automatic t_full_plain();
    ns = 1; sa[0] = 32'h0002_0000; sl[0] = 32'h10000;
    run_case("R6 full nosplit", 1'b0, 1'b0, 1'b0);
  endtask
  task automatic t_full_split();
    ns = 1; sa[0] = 32'h0002_0000; sl[0] = 32'h10000;
    run_case("R6 full split", 1'b1, 1'b0, 1'b1);
  endtask
  task automatic t_alt();
    ns = 2; sa[0] = 32'h0003_FFF0; sl[0] = 32'h20; sa[1] = 32'h0005_0000; sl[1] = 32'h10000;
    run_case("R7 alt", 1'b1, 1'b1, 1'b1);
  endtask
  task automatic t_exact_fit();
    ns = 1; sa[0] = 32'h0010_0000; sl[0] = 32'h40000;
    run_case("R8 exact fit", 1'b1, 1'b0, 1'b0);
  endtask
  task automatic t_overflow();
    ns = 3; sa[0] = 32'h0010_0000; sl[0] = 32'hA0000;
    sa[1] = 32'h0020_0000; sl[1] = 32'h100; sa[2] = 32'h0030_0000; sl[2] = 32'h100;
    run_case("R8 overflow", 1'b0, 1'b0, 1'b1);
    ns = 1; sa[0] = 32'h0040_0010; sl[0] = 32'h40;
    run_case("R8 recover", 1'b0, 1'b0, 1'b0);
  endtask
  task automatic t_empty();
    ns = 2; sa[0] = 32'h0000_1000; sl[0] = 32'h0; sa[1] = 32'h0000_2000; sl[1] = 32'h0;
    run_case("R9 empty", 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_small();
    t_cross();
    t_multi();
    t_full_plain();
    t_full_split();
    t_alt();
    t_exact_fit();
    t_overflow();
    t_empty();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule